// File: doc/BRIEF.md
# Sensor Serial Register Loader

This block writes one configuration word into an image sensor over a three-wire serial control port made of a data line, a serial clock and a latch strobe. The host presents four parallel fields (a fixed field, a gain field, an offset field and a shutter field) together with a one-cycle start request. The block captures the fields, shifts the resulting 38-bit word out least significant bit first, and then raises the latch strobe for one serial-clock period so the sensor takes the word. The serial clock is produced from the system clock by a fixed division of four, so it always stays below half the system clock rate.

The sensor forbids any activity on the three wires during a short window in its line sequence. An external input marks that window. A start request seen while the window is open is taken at once (busy rises), but nothing moves on the wires until the window closes. If the window opens during a transfer, the serial clock is parked low and the transfer resumes where it stopped, with no bit lost or repeated. A strobe that is already high stays high until the window closes.

The block reports busy while a transfer is outstanding and gives a one-cycle done pulse when it ends.

Top module: `sensor_cfg_loader`

## Requirements
- R1: After reset and whenever busy_o is low, sclk_o, sdi_o and load_o are all low and done_o is low except for its single pulse.
- R2: A start_i high on a rising clock edge while busy_o is low captures the word {shutter_i, offset_i, gain_i, fixed_i}: bits 9..0 from fixed_i, 19..10 from gain_i, 29..20 from offset_i and 37..30 from shutter_i. Bit 0 is sent first and later changes of the field inputs do not alter the word being sent.
- R3: During shifting each serial-clock period is four clock cycles, two low then two high, and a transfer makes exactly 38 rising edges of sclk_o.
- R4: sdi_o changes only when sclk_o falls or when shifting begins; it is stable while sclk_o is high, and at the k-th rising edge of sclk_o (counting from 0) it carries word bit k.
- R5: After the high half of the last bit, sclk_o and sdi_o stay low and load_o is high for exactly four clock cycles when forbid_i stays low.
- R6: A start accepted while forbid_i is high raises busy_o on the next cycle but keeps sclk_o, sdi_o and load_o low until forbid_i has been seen low; shifting begins two cycles after the start edge when forbid_i is low.
- R7: While forbid_i is high, sclk_o does not rise; if it rises during a high half, sclk_o completes that half, then stays low until forbid_i falls, and the transfer resumes with the next bit.
- R8: While forbid_i is high during the strobe, load_o stays high; the strobe lasts four cycles plus the number of cycles forbid_i was seen high in it.
- R9: busy_o is high from the cycle after an accepted start until the last strobe cycle; done_o is high for exactly the one cycle after it, with busy_o low.
- R10: A start_i while busy_o is high is ignored and does not disturb the running transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Transfer request, sampled on the rising edge |
| forbid_i | input | 1 | High while the sensor forbids wire activity |
| fixed_i | input | 10 | Fixed field, word bits 9..0 |
| gain_i | input | 10 | Gain field, word bits 19..10 |
| offset_i | input | 10 | Offset field, word bits 29..20 |
| shutter_i | input | 8 | Shutter field, word bits 37..30 |
| sclk_o | output | 1 | Serial clock to the sensor |
| sdi_o | output | 1 | Serial data to the sensor |
| load_o | output | 1 | Latch strobe to the sensor |
| busy_o | output | 1 | Transfer outstanding |
| done_o | output | 1 | One-cycle end-of-transfer pulse |

## Verification
On every cycle the assertions check that the wires are quiet when idle, that sclk_o never rises after a cycle with forbid_i high, that sdi_o holds through each high half, that the strobe excludes the serial clock and holds through the window, and that done_o is a lone pulse. Only the bench scenarios can show that the bits seen on the rising edges rebuild the exact captured word in order, that the edge count and strobe length are right, that fields changed mid-transfer and starts while busy leave the word untouched, and that pauses at different phases lose no bit.

// File: rtl/sensor_cfg_pkg.sv
package sensor_cfg_pkg;
  localparam int FIX_W  = 10;
  localparam int GAIN_W = 10;
  localparam int OFS_W  = 10;
  localparam int SHUT_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_SHIFT,
    ST_LATCH,
    ST_DONE
  } ld_state_e;
endpackage

// File: rtl/scl_pacer.sv
module scl_pacer #(
  parameter int DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic hold_i,
  output logic hi_o,
  output logic wrap_o
);
  localparam int PH_W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(DIV - 1);
  localparam logic [PH_W-1:0] PH_HALF = PH_W'(DIV / 2);

  logic [PH_W-1:0] ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q <= '0;
    end else if (!run_i) begin
      ph_q <= '0;
    end else if (!hold_i) begin
      ph_q <= (ph_q == PH_LAST) ? '0 : ph_q + 1'b1;
    end
  end

  assign hi_o   = run_i && (ph_q >= PH_HALF);
  assign wrap_o = run_i && !hold_i && (ph_q == PH_LAST);

  // held phase must not move
  a_r7_hold_freezes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && hold_i) |=> $stable(ph_q));
endmodule

// File: rtl/scl_shifter.sv
module scl_shifter #(
  parameter int W = 38
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] word_i,
  input  logic         shift_i,
  output logic         bit_o
);
  logic [W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q <= '0;
    end else if (load_i) begin
      sr_q <= word_i;
    end else if (shift_i) begin
      sr_q <= {1'b0, sr_q[W-1:1]};
    end
  end

  assign bit_o = sr_q[0];

  a_r4_bit_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !shift_i) |=> $stable(bit_o));
endmodule

// File: rtl/scl_ctrl.sv
module scl_ctrl
  import sensor_cfg_pkg::*;
#(
  parameter int W = 38
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      start_i,
  input  logic      forbid_i,
  input  logic      wrap_i,
  input  logic      hi_i,
  output ld_state_e state_o,
  output logic      run_o,
  output logic      hold_o,
  output logic      load_word_o,
  output logic      shift_o
);
  localparam int BC_W = $clog2(W);
  localparam logic [BC_W-1:0] BIT_LAST = BC_W'(W - 1);

  ld_state_e       state_q, state_d;
  logic [BC_W-1:0] bit_q, bit_d;
  logic            accept;

  assign accept = (state_q == ST_IDLE || state_q == ST_DONE) && start_i;

  always_comb begin
    state_d = state_q;
    bit_d   = bit_q;
    case (state_q)
      ST_IDLE, ST_DONE: state_d = accept ? ST_WAIT : ST_IDLE;
      ST_WAIT: begin
        if (!forbid_i) begin
          state_d = ST_SHIFT;
          bit_d   = '0;
        end
      end
      ST_SHIFT: begin
        if (wrap_i) begin
          if (bit_q == BIT_LAST) state_d = ST_LATCH;
          else                   bit_d   = bit_q + 1'b1;
        end
      end
      ST_LATCH: if (wrap_i) state_d = ST_DONE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
    end else begin
      state_q <= state_d;
      bit_q   <= bit_d;
    end
  end

  // park low: freeze only in low half while shifting, any phase while latching
  assign hold_o      = forbid_i && ((state_q == ST_SHIFT && !hi_i) || state_q == ST_LATCH);
  assign run_o       = (state_q == ST_SHIFT) || (state_q == ST_LATCH);
  assign load_word_o = accept;
  assign shift_o     = (state_q == ST_SHIFT) && wrap_i && (bit_q != BIT_LAST);
  assign state_o     = state_q;

  a_r10_shift_not_restarted: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SHIFT) |=> (state_q == ST_SHIFT || state_q == ST_LATCH));
  a_r6_wait_while_forbid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && forbid_i) |=> (state_q == ST_WAIT));
  a_r3_bit_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_q <= BIT_LAST);
endmodule

// File: rtl/sensor_cfg_loader.sv
module sensor_cfg_loader
  import sensor_cfg_pkg::*;
#(
  parameter int DIV = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              forbid_i,
  input  logic [FIX_W-1:0]  fixed_i,
  input  logic [GAIN_W-1:0] gain_i,
  input  logic [OFS_W-1:0]  offset_i,
  input  logic [SHUT_W-1:0] shutter_i,
  output logic              sclk_o,
  output logic              sdi_o,
  output logic              load_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int WORD_W = FIX_W + GAIN_W + OFS_W + SHUT_W;

  logic [WORD_W-1:0] word;
  ld_state_e         state;
  logic              run, hold, hi, wrap, load_word, shift, bit_out;

  assign word = {shutter_i, offset_i, gain_i, fixed_i};

  scl_ctrl #(.W(WORD_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .forbid_i    (forbid_i),
    .wrap_i      (wrap),
    .hi_i        (hi),
    .state_o     (state),
    .run_o       (run),
    .hold_o      (hold),
    .load_word_o (load_word),
    .shift_o     (shift)
  );

  scl_pacer #(.DIV(DIV)) u_pacer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .hold_i (hold),
    .hi_o   (hi),
    .wrap_o (wrap)
  );

  scl_shifter #(.W(WORD_W)) u_shifter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load_word),
    .word_i  (word),
    .shift_i (shift),
    .bit_o   (bit_out)
  );

  assign sclk_o = (state == ST_SHIFT) && hi;
  assign sdi_o  = (state == ST_SHIFT) && bit_out;
  assign load_o = (state == ST_LATCH);
  assign busy_o = (state == ST_WAIT) || (state == ST_SHIFT) || (state == ST_LATCH);
  assign done_o = (state == ST_DONE);

  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!sclk_o && !sdi_o && !load_o));
  a_r7_no_rise_in_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (forbid_i && !sclk_o) |=> !sclk_o);
  a_r4_sdi_stable_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |=> (!sclk_o || $stable(sdi_o)));
  a_r5_load_alone: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |-> (!sclk_o && !sdi_o && busy_o));
  a_r8_load_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_o && forbid_i) |=> load_o);
  a_r9_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && !$past(done_o)));
endmodule

// File: tb/sensor_cfg_loader_tb.sv
module sensor_cfg_loader_tb;
  localparam int W = 38;
  localparam int M_IDLE = 0, M_WAIT = 1, M_SHIFT = 2, M_LATCH = 3, M_DONE = 4;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0, forbid_i = 1'b0;
  logic [9:0] fixed_i = '0, gain_i = '0, offset_i = '0;
  logic [7:0] shutter_i = '0;
  logic sclk_o, sdi_o, load_o, busy_o, done_o;

  int checks = 0, failures = 0, cycles = 0;

  always #2 clk_i = ~clk_i;

  sensor_cfg_loader u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .forbid_i(forbid_i),
    .fixed_i(fixed_i), .gain_i(gain_i), .offset_i(offset_i), .shutter_i(shutter_i),
    .sclk_o(sclk_o), .sdi_o(sdi_o), .load_o(load_o), .busy_o(busy_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference model
  int m_mode = M_IDLE, m_ph = 0, m_bit = 0;
  logic [W-1:0] m_word = '0;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_mode = M_IDLE; m_ph = 0; m_bit = 0;
    end else begin
      case (m_mode)
        M_IDLE, M_DONE: begin
          if (start_i) begin
            m_word = {shutter_i, offset_i, gain_i, fixed_i};
            m_mode = M_WAIT;
          end else m_mode = M_IDLE;
        end
        M_WAIT: if (!forbid_i) begin m_mode = M_SHIFT; m_ph = 0; m_bit = 0; end
        M_SHIFT: begin
          if (!(forbid_i && m_ph < 2)) begin
            if (m_ph == 3) begin
              m_ph = 0;
              if (m_bit == W - 1) m_mode = M_LATCH; else m_bit++;
            end else m_ph++;
          end
        end
        default: begin
          if (!forbid_i) begin
            if (m_ph == 3) begin m_ph = 0; m_mode = M_DONE; end else m_ph++;
          end
        end
      endcase
    end
  end

  // per-cycle compare and monitor
  bit cmp_en = 0;
  logic prev_sclk = 0, forbid_d = 0;
  int rises = 0, load_len = 0, win_rises = 0;
  logic [W-1:0] got = '0;

  always @(negedge clk_i) begin
    if (cmp_en) begin
      chk(sclk_o == (m_mode == M_SHIFT && m_ph >= 2), "R3 sclk", sclk_o, 0);
      chk(sdi_o == ((m_mode == M_SHIFT) ? m_word[m_bit] : 1'b0), "R4 sdi", sdi_o, 0);
      chk(load_o == (m_mode == M_LATCH), "R5 load", load_o, m_mode == M_LATCH);
      chk(busy_o == (m_mode inside {M_WAIT, M_SHIFT, M_LATCH}), "R9 busy", busy_o, 0);
      chk(done_o == (m_mode == M_DONE), "R9 done", done_o, m_mode == M_DONE);
      if (sclk_o && !prev_sclk) begin
        if (rises < W) got[rises] = sdi_o;
        rises++;
        if (forbid_d) win_rises++;
      end
      if (load_o) load_len++;
      prev_sclk = sclk_o;
      forbid_d = forbid_i;
    end
  end

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 100000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic start_xfer(input logic [W-1:0] w);
    @(negedge clk_i);
    {shutter_i, offset_i, gain_i, fixed_i} = w;
    rises = 0; load_len = 0; win_rises = 0; got = '0;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic wait_done();
    while (!done_o) @(negedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic end_checks(input logic [W-1:0] w, input int extra);
    chk(got == w, "R2 word", got, w);
    chk(rises == W, "R3 rises", rises, W);
    chk(load_len == 4 + extra, "R5 R8 load_len", load_len, 4 + extra);
    chk(win_rises == 0, "R7 rises in window", win_rises, 0);
  endtask

  initial begin
    logic [W-1:0] wa, wb, wc, wd, we;
    wa = {8'hA5, 10'h155, 10'h2AA, 10'h3C3};
    wb = {8'h01, 10'h200, 10'h001, 10'h3FF};
    wc = {8'hFF, 10'h0F0, 10'h30F, 10'h001};
    wd = {8'h5A, 10'h111, 10'h222, 10'h333};
    we = {8'h80, 10'h3FE, 10'h000, 10'h2B7};

    repeat (3) @(negedge clk_i);
    chk(!sclk_o && !sdi_o && !load_o && !busy_o && !done_o, "R1 reset",
        {sclk_o, sdi_o, load_o, busy_o, done_o}, 0);
    rst_ni = 1'b1;
    cmp_en = 1;
    repeat (2) @(negedge clk_i);

    // R2 R3 R4 R5 plain transfer
    start_xfer(wa);
    chk(busy_o && !sclk_o, "R9 busy after start", busy_o, 1);
    wait_done();
    end_checks(wa, 0);
    chk(!busy_o && !sclk_o && !sdi_o && !load_o, "R1 idle after", busy_o, 0);

    // R2 field changes ignored, R10 start while busy ignored
    start_xfer(wb);
    repeat (20) @(negedge clk_i);
    {shutter_i, offset_i, gain_i, fixed_i} = ~wb;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    repeat (30) @(negedge clk_i);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    wait_done();
    end_checks(wb, 0);
    repeat (3) @(negedge clk_i);
    chk(!busy_o, "R10 no second transfer", busy_o, 0);

    // R6 start inside window
    @(negedge clk_i);
    forbid_i = 1'b1;
    start_xfer(wc);
    begin
      int bad = 0;
      for (int i = 0; i < 20; i++) begin
        if (!busy_o || sclk_o || sdi_o || load_o) bad++;
        @(negedge clk_i);
      end
      chk(bad == 0, "R6 quiet while pending", bad, 0);
    end
    forbid_i = 1'b0;
    wait_done();
    end_checks(wc, 0);

    // R7 window opens in low half and in high half
    start_xfer(wd);
    repeat (9) @(negedge clk_i);
    forbid_i = 1'b1;
    repeat (25) @(negedge clk_i);
    forbid_i = 1'b0;
    while (!sclk_o) @(negedge clk_i);
    forbid_i = 1'b1;
    repeat (9) @(negedge clk_i);
    chk(!sclk_o, "R7 parked low", sclk_o, 0);
    forbid_i = 1'b0;
    repeat (40) @(negedge clk_i);
    forbid_i = 1'b1;
    repeat (3) @(negedge clk_i);
    forbid_i = 1'b0;
    wait_done();
    end_checks(wd, 0);

    // R8 window during strobe; back-to-back start on done (R9)
    start_xfer(we);
    while (!load_o) @(negedge clk_i);
    forbid_i = 1'b1;
    repeat (6) @(negedge clk_i);
    forbid_i = 1'b0;
    while (!done_o) @(negedge clk_i);
    chk(!busy_o, "R9 done without busy", busy_o, 0);
    end_checks(we, 6);
    start_i = 1'b1;
    {shutter_i, offset_i, gain_i, fixed_i} = wa;
    rises = 0; load_len = 0; win_rises = 0; got = '0;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(busy_o, "R9 start on done cycle", busy_o, 1);
    wait_done();
    end_checks(wa, 0);

    repeat (4) @(negedge clk_i);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule